// File: doc/BRIEF.md
# Hysteresis Comparator Trigger Generator

This block watches a set of sampled analog channels and turns them into a compact status word and a trace trigger. Each channel's signed sample is compared against its own lower and upper threshold. The comparison yields a Schmitt-style hysteresis flag and a window (in-range) flag. All flags are refreshed together on a common sample strobe. The previous sample's flags are kept in the upper half of the same word, so a consumer can see the edges.

The trigger stage takes the freshly updated status word and XORs it with a programmed nominal pattern. It then masks the result with an enable mask. A per-bit operator mask sorts the conditions into an AND group and an OR group. When both groups are satisfied, the block emits a single-cycle trigger pulse that lines up with the new status word. A downstream recorder would use this pulse to freeze or dump its trace buffer.

Top module: `hyst_trig_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first strobe, the status word reads 0 and the trigger output is 0.
- R2: On a strobe, a channel's hysteresis flag becomes 1 when the sample is strictly greater than its upper threshold, and 0 when it is strictly less than its lower threshold. Otherwise, including a sample equal to either threshold, it keeps its previous value.
- R3: On a strobe, a channel's in-range flag becomes 1 when lower <= sample <= upper, and 0 otherwise.
- R4: Channel i (counted from 0) places its hysteresis flag at status bit 2i and its in-range flag at bit 2i+1. On each strobe the upper half (bits 15:8 for four channels) takes the lower half's previous contents. The first strobe after reset therefore loads zeros into the upper half.
- R5: Without a strobe, the status word does not change, whatever the samples and thresholds do.
- R6: With cond = (status XOR nominal) AND enable, the trigger fires when (cond AND NOT op) == 0 and (NOT cond AND op) != 0. An op bit of 1 marks an OR term and 0 marks an AND term.
- R7: The trigger never fires when op_mask is zero. An OR bit counts even when its enable bit is 0.
- R8: The trigger is evaluated once per strobe on the updated status word. It is high for exactly the one cycle in which the new status word is first visible, and is 0 in cycles that follow no strobe.
- R9: If a channel's lower threshold exceeds its upper threshold, its in-range flag is 0. The upper comparison takes precedence for the hysteresis flag, so a sample above the upper threshold sets it.
- R10: Samples and thresholds are two's-complement signed 16-bit values (for example, 0x8000 is below -100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | Sample strobe; one cycle per new sample set |
| smp_data | input | NUM_CH*SMP_W | Signed samples, channel 0 in the low slice |
| lo_thr | input | NUM_CH*SMP_W | Signed lower thresholds per channel |
| hi_thr | input | NUM_CH*SMP_W | Signed upper thresholds per channel |
| nominal | input | 4*NUM_CH | Expected status pattern |
| en_mask | input | 4*NUM_CH | Selects status bits that take part in the match |
| op_mask | input | 4*NUM_CH | Per-bit operator: 1 = OR term, 0 = AND term |
| status_word | output | 4*NUM_CH | Previous flags (upper half), current flags (lower half) |
| trig_pulse | output | 1 | Single-cycle trigger, aligned with the updated status word |

## Verification
The bench drives samples exactly at each threshold to catch an inclusive/exclusive mix-up. Such a design would drop the in-range flag or toggle the hysteresis flag on a boundary value. A strobe with 0x8000 exposes an unsigned comparison, which would set the hysteresis flag on the most negative input. Inverted thresholds check that a design testing the lower bound first does not clear a flag the upper bound should set. Trigger vectors cover an OR bit outside the enable mask, an all-zero operator mask and a fully disabled enable mask. A design that treated the OR group as optional, or masked op with enable, would fire or stay silent in the wrong place. Changing inputs without a strobe, and checking the trigger one cycle after a pulse, show up any status drift or stretched pulse.

// File: rtl/hyst_trig_pkg.sv
package hyst_trig_pkg;

  localparam int unsigned DEF_NUM_CH = 4;
  localparam int unsigned DEF_SMP_W  = 16;
  localparam int unsigned FLAGS_PER_CH = 2;

  // Bit offsets inside one channel's flag pair
  localparam int unsigned HYST_OFS = 0;
  localparam int unsigned WIN_OFS  = 1;

  typedef struct packed {
    logic win;
    logic hyst;
  } ch_flags_t;

endpackage

// File: rtl/htg_rst_sync.sv
module htg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/htg_chan_cmp.sv
module htg_chan_cmp
  import hyst_trig_pkg::*;
#(
  parameter int unsigned SMP_W = DEF_SMP_W
) (
  input  logic signed [SMP_W-1:0] sample,
  input  logic signed [SMP_W-1:0] lo_lim,
  input  logic signed [SMP_W-1:0] hi_lim,
  input  logic                    hyst_cur,
  output ch_flags_t               flags_nxt
);

  logic above_hi;
  logic below_lo;

  always_comb begin
    above_hi = (sample > hi_lim);
    below_lo = (sample < lo_lim);
    // Upper comparison has precedence when the limits are inverted
    if (above_hi) begin
      flags_nxt.hyst = 1'b1;
    end else if (below_lo) begin
      flags_nxt.hyst = 1'b0;
    end else begin
      flags_nxt.hyst = hyst_cur;
    end
    flags_nxt.win = !above_hi && !below_lo;
  end

endmodule

// File: rtl/htg_match.sv
module htg_match #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] status,
  input  logic [W-1:0] nominal,
  input  logic [W-1:0] en_mask,
  input  logic [W-1:0] op_mask,
  output logic         fire
);

  logic [W-1:0] cond;
  logic         and_ok;
  logic         or_ok;

  always_comb begin
    cond   = (status ^ nominal) & en_mask;
    and_ok = ((cond & ~op_mask) == '0);
    or_ok  = ((~cond & op_mask) != '0);
    fire   = and_ok && or_ok;
  end

endmodule

// File: rtl/hyst_trig_gen.sv
module hyst_trig_gen
  import hyst_trig_pkg::*;
#(
  parameter int unsigned NUM_CH = DEF_NUM_CH,
  parameter int unsigned SMP_W  = DEF_SMP_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      smp_valid,
  input  logic [NUM_CH*SMP_W-1:0]   smp_data,
  input  logic [NUM_CH*SMP_W-1:0]   lo_thr,
  input  logic [NUM_CH*SMP_W-1:0]   hi_thr,
  input  logic [4*NUM_CH-1:0]       nominal,
  input  logic [4*NUM_CH-1:0]       en_mask,
  input  logic [4*NUM_CH-1:0]       op_mask,
  output logic [4*NUM_CH-1:0]       status_word,
  output logic                      trig_pulse
);

  localparam int unsigned HALF_W = FLAGS_PER_CH * NUM_CH;
  localparam int unsigned STAT_W = 2 * HALF_W;

  logic              rst_sync_n;
  logic [STAT_W-1:0] status_q;
  logic [STAT_W-1:0] status_d;
  logic              trig_q;
  logic              trig_d;
  logic [HALF_W-1:0] cur_flags;
  logic [STAT_W-1:0] status_cand;
  logic              fire_w;

  htg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    ch_flags_t flags_w;

    htg_chan_cmp #(.SMP_W(SMP_W)) u_cmp (
      .sample    (smp_data[gi*SMP_W +: SMP_W]),
      .lo_lim    (lo_thr[gi*SMP_W +: SMP_W]),
      .hi_lim    (hi_thr[gi*SMP_W +: SMP_W]),
      .hyst_cur  (status_q[FLAGS_PER_CH*gi + HYST_OFS]),
      .flags_nxt (flags_w)
    );

    assign cur_flags[FLAGS_PER_CH*gi + HYST_OFS] = flags_w.hyst;
    assign cur_flags[FLAGS_PER_CH*gi + WIN_OFS]  = flags_w.win;
  end

  assign status_cand = {status_q[HALF_W-1:0], cur_flags};

  htg_match #(.W(STAT_W)) u_match (
    .status  (status_cand),
    .nominal (nominal),
    .en_mask (en_mask),
    .op_mask (op_mask),
    .fire    (fire_w)
  );

  // Next-state logic
  always_comb begin
    status_d = status_q;
    trig_d   = 1'b0;
    if (smp_valid) begin
      status_d = status_cand;
      trig_d   = fire_w;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      status_q <= '0;
      trig_q   <= 1'b0;
    end else begin
      status_q <= status_d;
      trig_q   <= trig_d;
    end
  end

  assign status_word = status_q;
  assign trig_pulse  = trig_q;

endmodule

// File: rtl/htg_checker.sv
module htg_checker #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned SMP_W  = 16
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    smp_valid,
  input logic [NUM_CH*SMP_W-1:0] smp_data,
  input logic [NUM_CH*SMP_W-1:0] lo_thr,
  input logic [NUM_CH*SMP_W-1:0] hi_thr,
  input logic [4*NUM_CH-1:0]     op_mask,
  input logic [4*NUM_CH-1:0]     status_word,
  input logic                    trig_pulse
);

  localparam int unsigned HALF_W = 2 * NUM_CH;
  localparam int unsigned STAT_W = 4 * NUM_CH;

  logic signed [SMP_W-1:0] s0;
  logic signed [SMP_W-1:0] lo0;
  logic signed [SMP_W-1:0] hi0;

  assign s0  = smp_data[SMP_W-1:0];
  assign lo0 = lo_thr[SMP_W-1:0];
  assign hi0 = hi_thr[SMP_W-1:0];

  assert_hyst_set_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (s0 > hi0)) |=> status_word[0]);

  assert_hyst_clr_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (s0 < lo0) && !(s0 > hi0)) |=> !status_word[0]);

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (s0 >= lo0) && (s0 <= hi0)) |=> status_word[1]);

  assert_history_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    smp_valid |=> (status_word[STAT_W-1:HALF_W] == $past(status_word[HALF_W-1:0])));

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !smp_valid |=> $stable(status_word));

  assert_or_needed_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_pulse |-> ($past(op_mask) != '0));

  assert_after_strobe_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    trig_pulse |-> $past(smp_valid));

  assert_inverted_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (smp_valid && (lo0 > hi0)) |=> !status_word[1]);

endmodule

bind hyst_trig_gen htg_checker #(
  .NUM_CH (NUM_CH),
  .SMP_W  (SMP_W)
) u_htg_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .smp_valid   (smp_valid),
  .smp_data    (smp_data),
  .lo_thr      (lo_thr),
  .hi_thr      (hi_thr),
  .op_mask     (op_mask),
  .status_word (status_word),
  .trig_pulse  (trig_pulse)
);

// File: tb/hyst_trig_gen_test.sv
`timescale 1ns/1ps
module hyst_trig_gen_test;

  localparam int unsigned NUM_CH = 4;
  localparam int unsigned SMP_W  = 16;
  localparam int unsigned NVEC   = 7;

  typedef struct packed {
    logic [15:0] s0;
    logic [15:0] s1;
    logic [15:0] s2;
    logic [15:0] s3;
    logic [15:0] nom;
    logic [15:0] en;
    logic [15:0] op;
    logic [15:0] exp_st;
    logic        exp_tr;
  } vec_t;

  // Thresholds: lower -100 (0xFF9C), upper +100 (0x0064) on every channel
  localparam vec_t VEC [NVEC] = '{
    '{16'h00C8, 16'h0000, 16'hFF38, 16'h0064, 16'h0089, 16'hFFFF, 16'h0000, 16'h0089, 1'b0},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h89AB, 16'h00FF, 16'h8000, 16'h89AB, 1'b1},
    '{16'hFF38, 16'h00C8, 16'h0064, 16'hFF9C, 16'h0000, 16'h0004, 16'h0004, 16'hABA4, 1'b0},
    '{16'hFF9C, 16'h0000, 16'h0065, 16'hFF9B, 16'hA41E, 16'hFFFF, 16'h0001, 16'hA41E, 1'b1},
    '{16'h7FFF, 16'h8000, 16'h0000, 16'h0000, 16'h1EB0, 16'h0001, 16'h0002, 16'h1EB1, 1'b0},
    '{16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF, 16'hB1BB, 1'b1},
    '{16'h0096, 16'h0096, 16'h0096, 16'h0096, 16'h0055, 16'hFF00, 16'h00FF, 16'hBB55, 1'b0}
  };

  logic                    clk;
  logic                    rst_n;
  logic                    smp_valid;
  logic [NUM_CH*SMP_W-1:0] smp_data;
  logic [NUM_CH*SMP_W-1:0] lo_thr;
  logic [NUM_CH*SMP_W-1:0] hi_thr;
  logic [4*NUM_CH-1:0]     nominal;
  logic [4*NUM_CH-1:0]     en_mask;
  logic [4*NUM_CH-1:0]     op_mask;
  logic [4*NUM_CH-1:0]     status_word;
  logic                    trig_pulse;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  hyst_trig_gen #(.NUM_CH(NUM_CH), .SMP_W(SMP_W)) uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data),
    .lo_thr      (lo_thr),
    .hi_thr      (hi_thr),
    .nominal     (nominal),
    .en_mask     (en_mask),
    .op_mask     (op_mask),
    .status_word (status_word),
    .trig_pulse  (trig_pulse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    smp_valid = 1'b1;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  initial begin
    rst_n     = 1'b0;
    smp_valid = 1'b0;
    smp_data  = '0;
    lo_thr    = {4{16'hFF9C}};
    hi_thr    = {4{16'h0064}};
    nominal   = '0;
    en_mask   = '0;
    op_mask   = 16'hFFFF;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1 status in reset", status_word, 16'h0000);
    check("R1 trigger in reset", {15'd0, trig_pulse}, 16'h0000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 status after release", status_word, 16'h0000);
    check("R1 trigger after release", {15'd0, trig_pulse}, 16'h0000);

    // Vector table: R2 R3 R4 R6 R7 R8 R10
    for (int i = 0; i < int'(NVEC); i++) begin
      smp_data = {VEC[i].s3, VEC[i].s2, VEC[i].s1, VEC[i].s0};
      nominal  = VEC[i].nom;
      en_mask  = VEC[i].en;
      op_mask  = VEC[i].op;
      strobe();
      check($sformatf("R2/R3/R4/R10 status vec %0d", i), status_word, VEC[i].exp_st);
      check($sformatf("R6/R7 trigger vec %0d", i), {15'd0, trig_pulse}, {15'd0, VEC[i].exp_tr});
      @(negedge clk);
      check($sformatf("R8 trigger drops vec %0d", i), {15'd0, trig_pulse}, 16'h0000);
    end

    // R5: inputs change with no strobe; the trigger terms would match
    smp_data = {4{16'h8000}};
    nominal  = 16'h0000;
    en_mask  = 16'h0000;
    op_mask  = 16'h0001;
    repeat (3) @(negedge clk);
    check("R5 status held without strobe", status_word, 16'hBB55);
    check("R8 no trigger without strobe", {15'd0, trig_pulse}, 16'h0000);

    // R9: inverted limits on channel 0
    do_reset();
    check("R1 status after mid-run reset", status_word, 16'h0000);
    lo_thr   = {{3{16'hFF9C}}, 16'h0064};
    hi_thr   = {{3{16'h0064}}, 16'hFF9C};
    smp_data = {4{16'h0000}};
    op_mask  = 16'h0000;
    strobe();
    check("R9 upper first, window clear", status_word, 16'h00A9);
    smp_data = {{3{16'h0000}}, 16'hFF6A};
    strobe();
    check("R9 below lower clears flag", status_word, 16'hA9A8);
    check("R7 no trigger with empty op mask", {15'd0, trig_pulse}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule